// File: doc/BRIEF.md
# Serial Synthesizer Configuration Register Bank

This block is the programming front end of a fractional-N frequency synthesizer control core. A host drives three wires: a serial clock, a data line and a latch enable. The block oversamples them with its own system clock, shifts 32-bit words in most significant bit first, and commits the word when latch enable rises. The three lowest bits of the word select one of six configuration registers. Addresses 6 and 7 are discarded.

Some settings take effect as soon as their register is written. These are the integer and fractional divide words, the counter reset, the charge-pump three-state control, the lock-detect pin mode and two raw payload registers. The remaining settings are double-buffered: modulus, phase, reference counter, reference doubler, reference halver and charge-pump current. A write to their own register only parks them as pending. They all move to the active outputs together on the next write to address 0. A phase word that is not below its modulus is refused and flagged.

A control state machine sequences each commit. `ST_IDLE` waits for a committed word. `IDLE_TO_DECODE` is taken when a word arrives, and the word is held. `ST_DECODE` writes the addressed register. From there, `DECODE_TO_XFER` is taken for address 0 and `DECODE_TO_IDLE` for any other address. `ST_XFER` copies every pending value to the active outputs, and `XFER_TO_IDLE` follows unconditionally.

Top module: `synth_cfg_regbank`

## Requirements
- R1: On each rising edge of `ser_clk`, `ser_data` is shifted into a 32-bit register, most significant bit first. On a rising edge of `ser_le`, the last 32 bits are committed, and bits [2:0] of the word give the target address.
- R2: Address 0 loads `int_val` from bits [30:15] and `frac_val` from bits [14:3], both at once.
- R3: Address 1 carries the modulus in bits [14:3] and the phase in bits [26:15], and both are double-buffered.
- R4: Pending double-buffered values reach `mod_val`, `phase_val`, `rcount_val`, `ref_dbl`, `ref_half` and `cp_current` only on a later write to address 0, and then all of them together.
- R5: Address 2 bit 3 drives `cnt_reset` at once. The output is 1 while the bit is 1 and 0 once a later word clears it.
- R6: Address 2 bit 4 drives `cp_tristate` at once.
- R7: Address 2 carries double-buffered fields: reference count in bits [14:5], doubler in bit 15, halver in bit 16 and current code in bits [20:17].
- R8: Address 5 bits [23:22] set the lock pin mode. Mode 00 and mode 10 drive `ld_pin` low. Mode 01 passes `lock_in` through. Mode 11 drives `ld_pin` high.
- R9: If an address-1 word has phase greater than or equal to its modulus, `phase_err` goes to 1 and neither pending value changes. A valid address-1 word clears `phase_err`.
- R10: Words addressed 6 or 7 change no output and no pending value.
- R11: Addresses 3 and 4 store bits [31:3] into `aux3_word` and `aux4_word` at once.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial wires |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch enable; a rising edge commits the word |
| lock_in | input | 1 | Digital lock indication from the core |
| int_val | output | 16 | Integer divide word |
| frac_val | output | 12 | Fractional word |
| mod_val | output | 12 | Active modulus |
| phase_val | output | 12 | Active phase word |
| rcount_val | output | 10 | Active reference counter value |
| ref_dbl | output | 1 | Active reference doubler enable |
| ref_half | output | 1 | Active reference divide-by-2 enable |
| cp_current | output | 4 | Active charge-pump current code |
| cnt_reset | output | 1 | R and N counter reset |
| cp_tristate | output | 1 | Charge-pump three-state |
| ld_pin | output | 1 | Lock-detect pin |
| phase_err | output | 1 | Refused phase word flag |
| aux3_word | output | 29 | Raw payload of address 3 |
| aux4_word | output | 29 | Raw payload of address 4 |

## Verification
Count from the system clock edge that first samples `ser_le` high. Immediate registers update four edges later. Double-buffered active outputs update five edges later, after a write to address 0. The bench drives every serial transition on a falling edge and holds each level for several system clocks, so the synchronizers never see a half-formed edge. It then waits ten system clocks after each commit before the scoreboard monitor compares, on a falling edge. That margin covers both latencies, and no word arrives before the previous one has settled.

// File: rtl/sfcfg_pkg.sv
package sfcfg_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 3;
    localparam int INT_W  = 16;
    localparam int FRAC_W = 12;
    localparam int PH_W   = 12;
    localparam int RC_W   = 10;
    localparam int CUR_W  = 4;
    localparam int AUX_W  = WORD_W - ADDR_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_XFER   = 2'd2
    } ctl_state_t;

    typedef struct packed {
        logic [FRAC_W-1:0] modv;
        logic [PH_W-1:0]   phase;
        logic [RC_W-1:0]   rcount;
        logic              dbl;
        logic              half;
        logic [CUR_W-1:0]  cur;
    } dbuf_t;
endpackage

// File: rtl/sfcfg_shifter.sv
module sfcfg_shifter
    import sfcfg_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic              word_stb,
    output logic [WORD_W-1:0] word_q
);
    logic [SYNC:0]       sck_p;
    logic [SYNC:0]       le_p;
    logic [SYNC-1:0]     dat_p;
    logic [WORD_W-1:0]   sh_q;
    logic                sck_rise;
    logic                le_rise;

    assign sck_rise = sck_p[SYNC-1] & ~sck_p[SYNC];
    assign le_rise  = le_p[SYNC-1]  & ~le_p[SYNC];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p    <= '0;
            le_p     <= '0;
            dat_p    <= '0;
            sh_q     <= '0;
            word_stb <= 1'b0;
            word_q   <= '0;
        end else begin
            sck_p    <= {sck_p[SYNC-1:0], ser_clk};
            le_p     <= {le_p[SYNC-1:0], ser_le};
            dat_p    <= {dat_p[SYNC-2:0], ser_data};
            word_stb <= le_rise;
            if (sck_rise) sh_q <= {sh_q[WORD_W-2:0], dat_p[SYNC-1]};
            if (le_rise)  word_q <= sh_q;
        end
    end

    // R1: a commit is a single-cycle strobe
    a_r1_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb);
endmodule

// File: rtl/sfcfg_ctrl.sv
module sfcfg_ctrl
    import sfcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_stb,
    input  logic [WORD_W-1:0] word_in,
    output logic [INT_W-1:0]  int_q,
    output logic [FRAC_W-1:0] frac_q,
    output dbuf_t             act_q,
    output logic              crst_q,
    output logic              tri_q,
    output logic [1:0]        ld_mode_q,
    output logic              err_q,
    output logic [AUX_W-1:0]  aux3_q,
    output logic [AUX_W-1:0]  aux4_q
);
    localparam int INT_LO = ADDR_W + FRAC_W;

    ctl_state_t        state_q, state_d;
    logic [WORD_W-1:0] hold_q;
    dbuf_t             pend_q;
    logic [ADDR_W-1:0] addr;
    logic [FRAC_W-1:0] w_mod;
    logic [PH_W-1:0]   w_ph;

    assign addr  = hold_q[ADDR_W-1:0];
    assign w_mod = hold_q[ADDR_W +: FRAC_W];
    assign w_ph  = hold_q[INT_LO +: PH_W];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (word_stb) state_d = ST_DECODE;
            ST_DECODE: state_d = (addr == '0) ? ST_XFER : ST_IDLE;
            ST_XFER:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            int_q     <= '0;
            frac_q    <= '0;
            pend_q    <= '0;
            act_q     <= '0;
            crst_q    <= 1'b0;
            tri_q     <= 1'b0;
            ld_mode_q <= 2'b00;
            err_q     <= 1'b0;
            aux3_q    <= '0;
            aux4_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (word_stb) hold_q <= word_in;
                ST_DECODE: begin
                    case (addr)
                        3'd0: begin
                            frac_q <= hold_q[ADDR_W +: FRAC_W];
                            int_q  <= hold_q[INT_LO +: INT_W];
                        end
                        3'd1: begin
                            if (w_ph < w_mod) begin
                                pend_q.modv  <= w_mod;
                                pend_q.phase <= w_ph;
                                err_q        <= 1'b0;
                            end else begin
                                err_q        <= 1'b1;
                            end
                        end
                        3'd2: begin
                            crst_q        <= hold_q[3];
                            tri_q         <= hold_q[4];
                            pend_q.rcount <= hold_q[5 +: RC_W];
                            pend_q.dbl    <= hold_q[15];
                            pend_q.half   <= hold_q[16];
                            pend_q.cur    <= hold_q[17 +: CUR_W];
                        end
                        3'd3: aux3_q <= hold_q[WORD_W-1:ADDR_W];
                        3'd4: aux4_q <= hold_q[WORD_W-1:ADDR_W];
                        3'd5: ld_mode_q <= hold_q[23:22];
                        default: ;
                    endcase
                end
                ST_XFER: act_q <= pend_q;
                default: ;
            endcase
        end
    end

    // R4: active double-buffered values move only in the transfer state
    a_r4_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_XFER) |=> $stable(act_q));

    // R9: an active phase is always below the active modulus (or all zero)
    a_r9_phase_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q.modv != '0 || act_q.phase != '0) |-> (act_q.phase < act_q.modv));

    // R10: addresses 6 and 7 leave every register unchanged
    a_r10_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && addr[2:1] == 2'b11) |=>
        ($stable(pend_q) && $stable(int_q) && $stable(frac_q) && $stable(aux3_q)
         && $stable(aux4_q) && $stable(ld_mode_q) && $stable(crst_q)
         && $stable(tri_q) && $stable(err_q)));

    // R1: each committed word is decoded exactly once
    a_r1_decode_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE) |=> (state_q != ST_DECODE));
endmodule

// File: rtl/synth_cfg_regbank.sv
module synth_cfg_regbank
    import sfcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    input  logic              lock_in,
    output logic [INT_W-1:0]  int_val,
    output logic [FRAC_W-1:0] frac_val,
    output logic [FRAC_W-1:0] mod_val,
    output logic [PH_W-1:0]   phase_val,
    output logic [RC_W-1:0]   rcount_val,
    output logic              ref_dbl,
    output logic              ref_half,
    output logic [CUR_W-1:0]  cp_current,
    output logic              cnt_reset,
    output logic              cp_tristate,
    output logic              ld_pin,
    output logic              phase_err,
    output logic [AUX_W-1:0]  aux3_word,
    output logic [AUX_W-1:0]  aux4_word
);
    logic              word_stb;
    logic [WORD_W-1:0] word_q;
    dbuf_t             act;
    logic [1:0]        ld_mode;

    sfcfg_shifter #(.SYNC(SYNC_STAGES)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_le   (ser_le),
        .word_stb (word_stb),
        .word_q   (word_q)
    );

    sfcfg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_stb  (word_stb),
        .word_in   (word_q),
        .int_q     (int_val),
        .frac_q    (frac_val),
        .act_q     (act),
        .crst_q    (cnt_reset),
        .tri_q     (cp_tristate),
        .ld_mode_q (ld_mode),
        .err_q     (phase_err),
        .aux3_q    (aux3_word),
        .aux4_q    (aux4_word)
    );

    assign mod_val    = act.modv;
    assign phase_val  = act.phase;
    assign rcount_val = act.rcount;
    assign ref_dbl    = act.dbl;
    assign ref_half   = act.half;
    assign cp_current = act.cur;

    always_comb begin
        unique case (ld_mode)
            2'b01:   ld_pin = lock_in;
            2'b11:   ld_pin = 1'b1;
            default: ld_pin = 1'b0;
        endcase
    end
endmodule

// File: tb/synth_cfg_regbank_test.sv
module synth_cfg_regbank_test;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0, lock_in = 1'b0;
    logic [15:0] int_val;
    logic [11:0] frac_val, mod_val, phase_val;
    logic [9:0]  rcount_val;
    logic        ref_dbl, ref_half, cnt_reset, cp_tristate, ld_pin, phase_err;
    logic [3:0]  cp_current;
    logic [28:0] aux3_word, aux4_word;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    typedef struct {
        int          sig;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_cfg_regbank uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .lock_in(lock_in), .int_val(int_val), .frac_val(frac_val),
        .mod_val(mod_val), .phase_val(phase_val), .rcount_val(rcount_val),
        .ref_dbl(ref_dbl), .ref_half(ref_half), .cp_current(cp_current),
        .cnt_reset(cnt_reset), .cp_tristate(cp_tristate), .ld_pin(ld_pin),
        .phase_err(phase_err), .aux3_word(aux3_word), .aux4_word(aux4_word)
    );

    function automatic logic [31:0] get_act(int sig);
        case (sig)
            0:  return 32'(int_val);
            1:  return 32'(frac_val);
            2:  return 32'(mod_val);
            3:  return 32'(phase_val);
            4:  return 32'(rcount_val);
            5:  return 32'(ref_dbl);
            6:  return 32'(ref_half);
            7:  return 32'(cp_current);
            8:  return 32'(cnt_reset);
            9:  return 32'(cp_tristate);
            10: return 32'(ld_pin);
            11: return 32'(phase_err);
            12: return 32'(aux3_word);
            default: return 32'(aux4_word);
        endcase
    endfunction

    // word builders: address in [2:0]
    function automatic logic [31:0] w_r0(logic [15:0] iv, logic [11:0] fv);
        return {1'b0, iv, fv, 3'd0};
    endfunction
    function automatic logic [31:0] w_r1(logic [11:0] md, logic [11:0] ph);
        return {5'b0, ph, md, 3'd1};
    endfunction
    function automatic logic [31:0] w_r2(logic [9:0] rc, logic dbl, logic half,
                                         logic [3:0] cur, logic tri3, logic crst);
        return {11'b0, cur, half, dbl, rc, tri3, crst, 3'd2};
    endfunction
    function automatic logic [31:0] w_r5(logic [1:0] mode);
        return {8'b0, mode, 19'b0, 3'd5};
    endfunction

    task automatic expect_val(int sig, logic [31:0] exp, string req);
        item_t it;
        it.sig = sig; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    // R1: MSB first, rising ser_clk samples, rising ser_le commits
    task automatic send_word(logic [31:0] w);
        for (int i = 31; i >= 0; i--) begin
            @(negedge clk); ser_data = w[i];
            repeat (HOLD) @(negedge clk); ser_clk = 1'b1;
            repeat (HOLD) @(negedge clk); ser_clk = 1'b0;
        end
        repeat (HOLD) @(negedge clk); ser_le = 1'b1;
        repeat (HOLD) @(negedge clk); ser_le = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic drain();
        @(negedge clk);
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] a;
                it = sb_q.pop_front();
                a = get_act(it.sig);
                n_run++;
                if (a !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s sig%0d actual=%0h expected=%0h", it.req, it.sig, a, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        expect_val(0, 0, "R12"); expect_val(2, 0, "R12"); expect_val(8, 0, "R12");
        expect_val(10, 0, "R12"); expect_val(11, 0, "R12"); expect_val(13, 0, "R12");
        drain();

        // R8 lock pin modes, written in initialization order starting at address 5
        send_word(w_r5(2'b01));
        lock_in = 1'b1; drain(); expect_val(10, 1, "R8"); drain();
        lock_in = 1'b0; drain(); expect_val(10, 0, "R8"); drain();
        send_word(w_r5(2'b11)); expect_val(10, 1, "R8"); drain();
        lock_in = 1'b1;
        send_word(w_r5(2'b10)); expect_val(10, 0, "R8"); drain();
        send_word(w_r5(2'b00)); expect_val(10, 0, "R8"); drain();

        // R11 raw payloads, R1 bit order
        send_word({29'h1ABC_DEF5, 3'd4}); expect_val(13, 32'h1ABC_DEF5, "R11"); drain();
        send_word({29'h0123_4567, 3'd3}); expect_val(12, 32'h0123_4567, "R11"); drain();

        // R5 R6 immediate, R7 held pending
        send_word(w_r2(10'h155, 1'b1, 1'b0, 4'd9, 1'b1, 1'b1));
        expect_val(8, 1, "R5"); expect_val(9, 1, "R6");
        expect_val(4, 0, "R7"); expect_val(7, 0, "R7"); drain();

        // R3 pending only
        send_word(w_r1(12'd100, 12'd40));
        expect_val(2, 0, "R3"); expect_val(3, 0, "R3"); expect_val(11, 0, "R9"); drain();

        // R2 and R4 transfer
        send_word(w_r0(16'h1234, 12'd55));
        expect_val(0, 16'h1234, "R2"); expect_val(1, 55, "R2");
        expect_val(2, 100, "R4"); expect_val(3, 40, "R4");
        expect_val(4, 10'h155, "R7"); expect_val(5, 1, "R7");
        expect_val(6, 0, "R7"); expect_val(7, 9, "R7"); drain();

        // R9 refused phase
        send_word(w_r1(12'd50, 12'd50)); expect_val(11, 1, "R9"); drain();
        send_word(w_r0(16'h0002, 12'd3));
        expect_val(2, 100, "R9"); expect_val(3, 40, "R9"); expect_val(0, 2, "R2"); drain();
        send_word(w_r1(12'd60, 12'd59)); expect_val(11, 0, "R9"); drain();

        // R10 unused addresses
        send_word({29'h1FFF_FFFF, 3'd6});
        send_word({29'h1FFF_FFFF, 3'd7});
        expect_val(0, 2, "R10"); expect_val(12, 32'h0123_4567, "R10");
        expect_val(13, 32'h1ABC_DEF5, "R10"); expect_val(10, 0, "R10");
        expect_val(8, 1, "R10"); expect_val(11, 0, "R10"); drain();
        send_word(w_r0(16'hFFFF, 12'hFFF));
        expect_val(2, 60, "R4"); expect_val(3, 59, "R4"); expect_val(4, 10'h155, "R10");
        expect_val(0, 16'hFFFF, "R2"); drain();

        // R5 R6 release
        send_word(w_r2(10'd1, 1'b0, 1'b1, 4'd2, 1'b0, 1'b0));
        expect_val(8, 0, "R5"); expect_val(9, 0, "R6"); expect_val(6, 0, "R4"); drain();

        repeat (5) @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule